// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical byte address into a memory channel, a rank within that channel and a flat rank index, using eight programmable boundary registers. Each boundary is a cumulative end address counted in 64 MiB granules, taken from address bits 35:26, so a rank covers the granules from the previous boundary of its channel up to its own boundary. A top-of-memory value marks the end of populated memory. Two channels are supported, each with four ranks, in either an interleaved layout (a low address bit chooses the channel) or a stacked layout (channel 1's memory sits above all of channel 0's). A mode flag can restrict the block to channel 0 only.

Software-style configuration arrives through a simple write port that selects one of ten register slots. Address requests use a valid/ready handshake and the decoded result is registered, so it appears one cycle after acceptance. A separate combinational port reports the size of any rank, in granules, including the correction that stacked channel-1 ranks need.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After reset, rspValid is low, every boundary, the top of memory and the single-channel flag read as zero, and reqReady is high from the first clock edge after reset release onward.
- R2: A write with cfgWrEn high stores cfgWrData according to cfgWrSel: values 0 to 7 select the boundary of rank cfgWrSel[1:0] on channel cfgWrSel[2], 8 selects the top of memory, 9 sets the single-channel flag from cfgWrData[0], and 10 to 15 change nothing. A request accepted in the same cycle as a write still decodes with the old value; requests accepted later use the new one.
- R3: rspValid is high in exactly the cycle after a cycle with reqValid and reqReady both high, and the response fields hold until the next accepted request.
- R4: The granule is address bits 35:26. A granule at or above the top of memory gives rspOutOfRange high with channel 0, rank 0 and index 0.
- R5: Within the chosen channel the rank is the lowest-numbered rank whose boundary is strictly greater than the compare granule, so empty ranks are never chosen; if no rank qualifies the response is out of range with channel 0, rank 0.
- R6: In the interleaved layout (dual channel, not stacked) the channel is address bit INTLV_BIT (default 6) and the granule is compared against that channel's boundaries.
- R7: The layout is stacked when the single-channel flag is clear and the channel-1 rank 3 boundary equals the top of memory; then a granule at or above the channel-0 rank 3 boundary goes to channel 1, any other to channel 0, and both channels compare the unmodified granule.
- R8: With the single-channel flag set, every in-range response names channel 0 and the layout is never stacked.
- R9: rspIndex equals channel times 4 plus the rank.
- R10: sizeOut reports, for rank sizeSel[1:0] of channel sizeSel[2], its boundary minus the previous boundary of the same channel (zero for rank 0), saturating at zero.
- R11: In the stacked layout a non-empty channel-1 rank whose boundary equals the channel-1 rank 3 boundary has the channel-0 rank 3 boundary subtracted from its size, saturating at zero; with the single-channel flag set all channel-1 sizes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 4 | Configuration slot select |
| cfgWrData | input | 10 | Configuration write value |
| reqValid | input | 1 | Address request valid |
| reqReady | output | 1 | Block accepts requests |
| reqAddr | input | 36 | Physical byte address |
| rspValid | output | 1 | Decode result valid |
| rspChannel | output | 1 | Decoded channel |
| rspRank | output | 2 | Decoded rank within channel |
| rspIndex | output | 3 | Flat rank index |
| rspOutOfRange | output | 1 | Address not backed by any rank |
| sizeSel | input | 3 | Rank selected for size report |
| sizeOut | output | 10 | Size of selected rank in granules |

## Verification
The bench sweeps every granule from zero past the top of memory with both values of the channel-select bit under an interleaved layout containing empty ranks, a stacked layout and single-channel mode, so a decoder that picked an empty rank, used a non-strict comparison or chose the wrong channel would return the wrong rank or index at the boundary granules. The stacked size correction is checked with both a positive result and an underflow, which a decoder lacking saturation would report as a huge size. A write issued in the same cycle as a request catches a design that lets new configuration leak into an already accepted request, and out-of-range granules catch a design that reports a stale rank instead of rank 0.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int RBD_NUM_CH       = 2;
  localparam int RBD_RANKS_PER_CH = 4;
  localparam int RBD_NUM_RANKS    = RBD_NUM_CH * RBD_RANKS_PER_CH;
  localparam int RBD_SEL_W        = 4;

  localparam logic [RBD_SEL_W-1:0] SEL_TOM  = 4'd8;
  localparam logic [RBD_SEL_W-1:0] SEL_MODE = 4'd9;

  typedef struct packed {
    logic [RBD_NUM_RANKS-1:0] loadBound;
    logic                     loadTom;
    logic                     loadMode;
    logic                     capture;
  } rbdStrobes_t;
endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [RBD_SEL_W-1:0] cfgWrSel,
  input  logic                 reqValid,
  output logic                 reqReady,
  output rbdStrobes_t          strobes
);
  logic readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady = readyQ;

  always_comb begin
    strobes = '0;
    if (cfgWrEn) begin
      if (cfgWrSel < RBD_SEL_W'(RBD_NUM_RANKS))
        strobes.loadBound[cfgWrSel[$clog2(RBD_NUM_RANKS)-1:0]] = 1'b1;
      strobes.loadTom  = (cfgWrSel == SEL_TOM);
      strobes.loadMode = (cfgWrSel == SEL_MODE);
    end
    strobes.capture = reqValid && readyQ;
  end
endmodule

// File: rtl/rbd_datapath.sv
module rbd_datapath
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 36,
  parameter int BOUND_W     = 10,
  parameter int GRAIN_SHIFT = 26,
  parameter int INTLV_BIT   = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rbdStrobes_t                      strobes,
  input  logic [BOUND_W-1:0]               cfgWrData,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [$clog2(RBD_NUM_RANKS)-1:0] sizeSel,
  output logic                             rspValid,
  output logic                             rspChannel,
  output logic [$clog2(RBD_RANKS_PER_CH)-1:0] rspRank,
  output logic                             rspOutOfRange,
  output logic [BOUND_W-1:0]               sizeOut
);
  localparam int RANK_W = $clog2(RBD_RANKS_PER_CH);
  localparam int LAST   = RBD_RANKS_PER_CH - 1;
  localparam int DIFF_W = BOUND_W + 1;

  logic [BOUND_W-1:0] bndQ [RBD_NUM_CH][RBD_RANKS_PER_CH];
  logic [BOUND_W-1:0] tomQ;
  logic               singleQ;

  // configuration storage
  generate
    for (genvar c = 0; c < RBD_NUM_CH; c++) begin : gCh
      for (genvar r = 0; r < RBD_RANKS_PER_CH; r++) begin : gRk
        always_ff @(posedge clk) begin
          if (!rstN) bndQ[c][r] <= '0;
          else if (strobes.loadBound[c*RBD_RANKS_PER_CH + r]) bndQ[c][r] <= cfgWrData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tomQ    <= '0;
      singleQ <= 1'b0;
    end else begin
      if (strobes.loadTom)  tomQ    <= cfgWrData;
      if (strobes.loadMode) singleQ <= cfgWrData[0];
    end
  end

  // layout detection
  logic stacked;
  assign stacked = !singleQ && (bndQ[1][LAST] == tomQ);

  logic [BOUND_W-1:0] granule;
  assign granule = reqAddr[GRAIN_SHIFT +: BOUND_W];

  // per-channel lowest-rank search
  logic              chHit  [RBD_NUM_CH];
  logic [RANK_W-1:0] chRank [RBD_NUM_CH];

  generate
    for (genvar c = 0; c < RBD_NUM_CH; c++) begin : gSearch
      always_comb begin
        chHit[c]  = 1'b0;
        chRank[c] = '0;
        for (int r = LAST; r >= 0; r--) begin
          if (granule < bndQ[c][r]) begin
            chHit[c]  = 1'b1;
            chRank[c] = RANK_W'(r);
          end
        end
      end
    end
  endgenerate

  // channel choice and result
  logic              selCh;
  logic              nextOor;
  logic              nextCh;
  logic [RANK_W-1:0] nextRank;

  always_comb begin
    if (singleQ)      selCh = 1'b0;
    else if (stacked) selCh = (granule >= bndQ[0][LAST]);
    else              selCh = reqAddr[INTLV_BIT];
    nextOor  = (granule >= tomQ) || !chHit[selCh];
    nextCh   = nextOor ? 1'b0 : selCh;
    nextRank = nextOor ? '0 : chRank[selCh];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspChannel    <= 1'b0;
      rspRank       <= '0;
      rspOutOfRange <= 1'b0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspChannel    <= nextCh;
        rspRank       <= nextRank;
        rspOutOfRange <= nextOor;
      end
    end
  end

  // rank size report
  logic              sizeCh;
  logic [RANK_W-1:0] sizeRk;
  logic [BOUND_W-1:0] curB;
  logic [BOUND_W-1:0] prevB;
  logic [DIFF_W-1:0]  diff;
  logic [DIFF_W-1:0]  adj;

  assign sizeCh = sizeSel[RANK_W];
  assign sizeRk = sizeSel[RANK_W-1:0];

  always_comb begin
    curB  = bndQ[sizeCh][sizeRk];
    prevB = (sizeRk == '0) ? '0 : bndQ[sizeCh][sizeRk - 1'b1];
    diff  = {1'b0, curB} - {1'b0, prevB};
    if (diff[DIFF_W-1]) diff = '0;
    adj = diff;
    if (stacked && sizeCh && (curB == bndQ[1][LAST]) && (diff != '0)) begin
      adj = diff - {1'b0, bndQ[0][LAST]};
      if (adj[DIFF_W-1]) adj = '0;
    end
    if (singleQ && sizeCh) adj = '0;
    sizeOut = adj[BOUND_W-1:0];
  end
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 36,
  parameter int BOUND_W     = 10,
  parameter int GRAIN_SHIFT = 26,
  parameter int INTLV_BIT   = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [3:0]   cfgWrSel,
  input  logic [BOUND_W-1:0] cfgWrData,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic         rspValid,
  output logic         rspChannel,
  output logic [1:0]   rspRank,
  output logic [2:0]   rspIndex,
  output logic         rspOutOfRange,
  input  logic [2:0]   sizeSel,
  output logic [BOUND_W-1:0] sizeOut
);
  rbdStrobes_t strobes;

  rbd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrSel (cfgWrSel),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  rbd_datapath #(
    .ADDR_W      (ADDR_W),
    .BOUND_W     (BOUND_W),
    .GRAIN_SHIFT (GRAIN_SHIFT),
    .INTLV_BIT   (INTLV_BIT)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .cfgWrData     (cfgWrData),
    .reqAddr       (reqAddr),
    .sizeSel       (sizeSel),
    .rspValid      (rspValid),
    .rspChannel    (rspChannel),
    .rspRank       (rspRank),
    .rspOutOfRange (rspOutOfRange),
    .sizeOut       (sizeOut)
  );

  assign rspIndex = {rspChannel, rspRank};
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [3:0] cfgWrSel,
  input logic [9:0] cfgWrData,
  input logic       reqValid,
  input logic       reqReady,
  input logic       rspValid,
  input logic       rspChannel,
  input logic [1:0] rspRank,
  input logic [2:0] rspIndex,
  input logic       rspOutOfRange
);
  logic singleShadow;

  always_ff @(posedge clk) begin
    if (!rstN) singleShadow <= 1'b0;
    else if (cfgWrEn && cfgWrSel == 4'd9) singleShadow <= cfgWrData[0];
  end

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> reqReady); // R1
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R3
  AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid); // R3
  AST_RSP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> $stable(rspIndex) && $stable(rspOutOfRange)); // R3
  AST_OOR_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspOutOfRange) |-> (rspChannel == 1'b0 && rspRank == 2'd0)); // R4
  AST_SINGLE_CH0: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(singleShadow)) |-> (rspChannel == 1'b0)); // R8
  AST_INDEX_FORM: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspIndex == {rspChannel, rspRank})); // R9
endmodule

bind rank_boundary_decoder rbd_checker uChk (
  .clk           (clk),
  .rstN          (rstN),
  .cfgWrEn       (cfgWrEn),
  .cfgWrSel      (cfgWrSel),
  .cfgWrData     (cfgWrData),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .rspValid      (rspValid),
  .rspChannel    (rspChannel),
  .rspRank       (rspRank),
  .rspIndex      (rspIndex),
  .rspOutOfRange (rspOutOfRange)
);

// File: tb/tb_rank_boundary_decoder.sv
`timescale 1ns/1ps
module tb_rank_boundary_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrSel = '0;
  logic [9:0]  cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [35:0] reqAddr = '0;
  logic        rspValid;
  logic        rspChannel;
  logic [1:0]  rspRank;
  logic [2:0]  rspIndex;
  logic        rspOutOfRange;
  logic [2:0]  sizeSel = '0;
  logic [9:0]  sizeOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench copy of configuration, written from the requirements
  int bnd [2][4];
  int tom = 0;
  bit single = 1'b0;

  always #2 clk = ~clk;

  rank_boundary_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspChannel(rspChannel),
    .rspRank(rspRank), .rspIndex(rspIndex), .rspOutOfRange(rspOutOfRange),
    .sizeSel(sizeSel), .sizeOut(sizeOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = 4'(sel); cfgWrData = 10'(val);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel < 8) bnd[sel/4][sel%4] = val;
    else if (sel == 8) tom = val;
    else if (sel == 9) single = val[0];
  endtask

  function automatic bit isStacked();
    return !single && (bnd[1][3] == tom);
  endfunction

  // expected {oor, channel, rank}
  function automatic int model(input int g, input bit ib);
    int ch, rk;
    if (single) ch = 0;
    else if (isStacked()) ch = (g >= bnd[0][3]) ? 1 : 0;
    else ch = ib;
    if (g >= tom) return 8;
    rk = -1;
    for (int r = 3; r >= 0; r--) if (g < bnd[ch][r]) rk = r;
    if (rk < 0) return 8;
    return ch * 4 + rk;
  endfunction

  function automatic int sizeModel(input int s);
    int ch = s / 4, rk = s % 4, d;
    d = bnd[ch][rk] - ((rk == 0) ? 0 : bnd[ch][rk-1]);
    if (d < 0) d = 0;
    if (isStacked() && ch == 1 && bnd[1][rk] == bnd[1][3] && d != 0) begin
      d = d - bnd[0][3];
      if (d < 0) d = 0;
    end
    if (single && ch == 1) d = 0;
    return d;
  endfunction

  task automatic decode(input int g, input bit ib, input string req);
    int exp;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = {10'(g), 26'h2A5A525 | (26'(ib) << 6)};
    @(negedge clk);
    reqValid = 1'b0;
    exp = model(g, ib);
    check({req, " valid"}, int'(rspValid), 1);
    check({req, " oor R4 R5"}, int'(rspOutOfRange), exp == 8 ? 1 : 0);
    check({req, " index R9"}, int'(rspIndex), exp == 8 ? 0 : exp);
    check({req, " channel R6 R7"}, int'(rspChannel), exp == 8 ? 0 : exp / 4);
  endtask

  task automatic sweep(input string req);
    for (int g = 0; g < 15; g++)
      for (int b = 0; b < 2; b++) decode(g, b[0], req);
    decode(1023, 1'b1, req);
  endtask

  task automatic sizes(input string req);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      sizeSel = 3'(s);
      #1 check(req, int'(sizeOut), sizeModel(s));
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) bnd[c][r] = 0;
    repeat (3) @(negedge clk);
    check("R1 rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", int'(reqReady), 1);
    check("R1 size zero", int'(sizeOut), 0);
    check("R3 no rsp idle", int'(rspValid), 0);
    decode(0, 1'b0, "R1 zero config oor");

    // interleaved layout with empty ranks (R2 R5 R6)
    wr(0, 2); wr(1, 2); wr(2, 5); wr(3, 8);
    wr(4, 1); wr(5, 3); wr(6, 3); wr(7, 6);
    wr(8, 12);
    wr(12, 1000); // R2 unused slot: changes nothing
    sweep("R6 interleaved");
    sizes("R10 sizes interleaved");

    // single-channel mode (R8 R11)
    wr(9, 1);
    sweep("R8 single");
    sizes("R11 single sizes");
    wr(9, 0);

    // stacked layout: channel 1 above channel 0 (R7 R11)
    wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 4);
    wr(4, 9); wr(5, 9); wr(6, 9); wr(7, 9);
    wr(8, 9);
    sweep("R7 stacked");
    sizes("R11 stacked sizes");
    wr(4, 6); wr(5, 6); wr(6, 8);
    sweep("R7 stacked multi");
    sizes("R11 stacked multi sizes");
    // underflow saturation
    wr(4, 2); wr(5, 2); wr(6, 2); wr(7, 2); wr(8, 2);
    sizes("R11 saturation");

    // write in same cycle as a request (R2)
    wr(0, 2); wr(1, 2); wr(2, 5); wr(3, 8);
    wr(4, 1); wr(5, 3); wr(6, 3); wr(7, 6); wr(8, 12);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {10'd4, 26'd0};
    cfgWrEn = 1'b1; cfgWrSel = 4'd8; cfgWrData = 10'd4;
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    check("R2 old tom used oor", int'(rspOutOfRange), 0);
    check("R2 old tom used rank", int'(rspRank), 2);
    tom = 4;
    decode(4, 1'b0, "R2 new tom");
    decode(3, 1'b0, "R2 new tom in range");

    // hold after response (R3)
    @(negedge clk);
    check("R3 valid drops", int'(rspValid), 0);
    check("R3 index holds", int'(rspIndex), model(3, 1'b0));

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule